// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Conversion Sequencer

This block controls a 10-bit successive-approximation converter. It drives a trial code to an external DAC, reads back a single comparator bit each clock, and builds the result one bit per cycle, starting at the most significant bit. Each finished result goes into a data register that belongs to the converted channel. Software reads these registers through a channel select and a read data port.

The block has two modes. In single mode it converts the selected channel once. The start bit then clears itself and the block returns to idle. In scan mode it converts channels 0 up to the selected channel in ascending order, which gives a group of one to four channels. It sets the done flag once the whole group has finished and then starts over at channel 0. This repeats for as long as the start bit stays set.

A conversion starts when the start bit becomes 1. Either a software control write or a one-cycle external trigger pulse can set it. Software must clear the start bit before it selects a different mode or channel. A write that sets the start bit may also load the mode and channel.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the start bit, done flag, interrupt line, busy and the end-of-conversion pulse are 0, scan mode is off, the selected channel is 0, and every channel data register reads 0.
- R2: In single mode (`scanMode`=0), a conversion of channel `chSel` produces the largest 10-bit code C for which the comparator reports the input at or above C. The comparator input is 1 when the input is at or above `dacCode`, and a trial bit is kept when it reads 1. The code is stored in data register `chSel`, and the other data registers are left unchanged.
- R3: A conversion takes one sample cycle (`sampleEn`=1) and then 10 compare cycles. In single mode the start bit reads 0, the done flag reads 1 and `busy` reads 0 on the 12th rising edge after the edge that took the write setting the start bit.
- R4: In scan mode (`scanMode`=1) the block converts channels 0, 1, ... up to `chSel` in ascending order and stores each result in that channel's register. `convCh` never exceeds `chSel` while the block is busy.
- R5: In scan mode the done flag rises only on the edge that stores the result of channel `chSel`. The start bit stays 1, and conversion then begins again at channel 0 for as long as the start bit is 1.
- R6: Clearing the start bit during a scan stops conversion. `busy` falls within two cycles, no further result is stored, and the done flag is not set for the unfinished group.
- R7: A one-cycle pulse on `extTrig` sets the start bit on that edge and starts a conversion with the current mode and channel. If it coincides with a control write, the start bit becomes 1.
- R8: A control write taken while the start bit is already 1 leaves `scanMode` and `chSel` unchanged. The start bit, interrupt enable and done-clear fields of that write still apply.
- R9: The done flag stays 1 until a control write with `wrDone`=0. A write with `wrDone`=1 leaves it unchanged. If the hardware sets the flag on the same edge as a clearing write, the flag ends up 1.
- R10: `irq` is 1 exactly when the done flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWr | input | 1 | Control register write strobe |
| wrStart | input | 1 | Start bit value written |
| wrScan | input | 1 | Mode value written (1 = scan) |
| wrCh | input | 2 | Channel / group-end value written |
| wrIntEn | input | 1 | Interrupt enable value written |
| wrDone | input | 1 | Done flag write (0 clears, 1 keeps) |
| extTrig | input | 1 | External start trigger, one-cycle pulse |
| compIn | input | 1 | Comparator: 1 when input >= dacCode |
| rdSel | input | 2 | Data register read select |
| rdData | output | 10 | Data register of channel rdSel |
| dacCode | output | 10 | Trial code for the DAC |
| sampleEn | output | 1 | Sample phase of a conversion |
| convCh | output | 2 | Channel being converted |
| startBit | output | 1 | Start/busy control bit |
| scanMode | output | 1 | Current mode |
| chSel | output | 2 | Current channel / group end |
| doneFlag | output | 1 | Conversion done flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Sequencer not idle |
| eocPulse | output | 1 | One-cycle pulse after each stored result |

## Verification
Two events can land on the same clock edge. One is the hardware setting the done flag at the end of a conversion. The other is a software control write that clears the same flag. The bench counts edges from the write that starts a single conversion and places a done-clearing write exactly on the 12th edge, which is the edge that stores the result. The done flag must read 1 afterwards, and the scoreboard must still receive the correct result for that conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSample;  // prepare a fresh search at the MSB
    logic stepBit;     // resolve the current trial bit
    logic storeRes;    // write the resolved code to the channel bank
  } dp_strobe_t;

endpackage

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PTR_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic             compIn,
  input  logic [CH_W-1:0]  storeCh,
  input  logic [CH_W-1:0]  rdSel,
  output logic [RES_W-1:0] dacCode,
  output logic             lastBit,
  output logic [RES_W-1:0] rdData
);

  logic [RES_W-1:0] sarAcc;
  logic [PTR_W-1:0] bitPtr;
  logic [RES_W-1:0] trialMask;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] bank [NUM_CH];

  assign trialMask = RES_W'(1) << bitPtr;
  assign dacCode   = sarAcc | trialMask;
  assign decided   = compIn ? dacCode : sarAcc;
  assign lastBit   = (bitPtr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarAcc <= '0;
      bitPtr <= PTR_W'(RES_W - 1);
    end else if (strobe.loadSample) begin
      sarAcc <= '0;
      bitPtr <= PTR_W'(RES_W - 1);
    end else if (strobe.stepBit) begin
      sarAcc <= decided;
      if (bitPtr != '0) bitPtr <= bitPtr - 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank[g] <= '0;
      end else if (strobe.storeRes && (storeCh == CH_W'(g))) begin
        bank[g] <= decided;
      end
    end
  end

  assign rdData = bank[rdSel];

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctrlWr,
  input  logic            wrStart,
  input  logic            wrScan,
  input  logic [CH_W-1:0] wrCh,
  input  logic            wrIntEn,
  input  logic            wrDone,
  input  logic            extTrig,
  input  logic            lastBit,
  output dp_strobe_t      strobe,
  output logic [CH_W-1:0] convCh,
  output logic            startBit,
  output logic            scanMode,
  output logic [CH_W-1:0] chSel,
  output logic            intEn,
  output logic            doneFlag,
  output logic            busy,
  output logic            sampleEn,
  output logic            eocPulse
);

  seq_state_t state, stNext;
  logic groupEnd;
  logic selfClear;

  always_comb begin
    stNext    = state;
    strobe    = '0;
    groupEnd  = 1'b0;
    selfClear = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startBit) stNext = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (!startBit) begin
          stNext = ST_IDLE;
        end else begin
          strobe.loadSample = 1'b1;
          stNext = ST_CONV;
        end
      end
      ST_CONV: begin
        if (!startBit) begin
          stNext = ST_IDLE;
        end else begin
          strobe.stepBit = 1'b1;
          if (lastBit) begin
            strobe.storeRes = 1'b1;
            if (!scanMode) begin
              groupEnd  = 1'b1;
              selfClear = 1'b1;
              stNext    = ST_IDLE;
            end else begin
              groupEnd = (convCh == chSel);
              stNext   = ST_SAMPLE;
            end
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stNext;
    end
  end

  // channel pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convCh <= '0;
    end else if (state == ST_IDLE && startBit) begin
      convCh <= scanMode ? '0 : chSel;
    end else if (strobe.storeRes && scanMode) begin
      convCh <= groupEnd ? '0 : convCh + 1'b1;
    end
  end

  // control register fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit <= 1'b0;
      scanMode <= 1'b0;
      chSel    <= '0;
      intEn    <= 1'b0;
    end else begin
      if (ctrlWr) begin
        startBit <= wrStart;
        intEn    <= wrIntEn;
        if (!startBit) begin
          scanMode <= wrScan;
          chSel    <= wrCh;
        end
      end else if (selfClear) begin
        startBit <= 1'b0;
      end
      if (extTrig) startBit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
    end else if (groupEnd) begin
      doneFlag <= 1'b1;
    end else if (ctrlWr && !wrDone) begin
      doneFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eocPulse <= 1'b0;
    end else begin
      eocPulse <= strobe.storeRes;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign sampleEn = (state == ST_SAMPLE);

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             wrStart,
  input  logic             wrScan,
  input  logic [CH_W-1:0]  wrCh,
  input  logic             wrIntEn,
  input  logic             wrDone,
  input  logic             extTrig,
  input  logic             compIn,
  input  logic [CH_W-1:0]  rdSel,
  output logic [RES_W-1:0] rdData,
  output logic [RES_W-1:0] dacCode,
  output logic             sampleEn,
  output logic [CH_W-1:0]  convCh,
  output logic             startBit,
  output logic             scanMode,
  output logic [CH_W-1:0]  chSel,
  output logic             doneFlag,
  output logic             irq,
  output logic             busy,
  output logic             eocPulse
);

  dp_strobe_t strobe;
  logic lastBit;
  logic intEn;

  sar_seq_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWr   (ctrlWr),
    .wrStart  (wrStart),
    .wrScan   (wrScan),
    .wrCh     (wrCh),
    .wrIntEn  (wrIntEn),
    .wrDone   (wrDone),
    .extTrig  (extTrig),
    .lastBit  (lastBit),
    .strobe   (strobe),
    .convCh   (convCh),
    .startBit (startBit),
    .scanMode (scanMode),
    .chSel    (chSel),
    .intEn    (intEn),
    .doneFlag (doneFlag),
    .busy     (busy),
    .sampleEn (sampleEn),
    .eocPulse (eocPulse)
  );

  sar_seq_dp #(.RES_W(RES_W), .NUM_CH(NUM_CH)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .compIn  (compIn),
    .storeCh (convCh),
    .rdSel   (rdSel),
    .dacCode (dacCode),
    .lastBit (lastBit),
    .rdData  (rdData)
  );

  assign irq = doneFlag & intEn;

endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            startBit,
  input logic            doneFlag,
  input logic            irq,
  input logic            busy,
  input logic            eocPulse,
  input logic            scanMode,
  input logic [CH_W-1:0] chSel,
  input logic [CH_W-1:0] convCh
);

  assert_group_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (scanMode && busy) |-> (convCh <= chSel));

  assert_done_with_result_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> eocPulse);

  assert_stop_goes_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !startBit) |=> !busy);

  assert_sel_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(startBit) |-> ($stable(scanMode) && $stable(chSel)));

  assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !doneFlag |-> !irq);

endmodule

bind sar_seq_top sar_seq_checker #(.CH_W(CH_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .startBit (startBit),
  .doneFlag (doneFlag),
  .irq      (irq),
  .busy     (busy),
  .eocPulse (eocPulse),
  .scanMode (scanMode),
  .chSel    (chSel),
  .convCh   (convCh)
);

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0;
  logic       wrStart = 1'b0;
  logic       wrScan = 1'b0;
  logic [1:0] wrCh = '0;
  logic       wrIntEn = 1'b0;
  logic       wrDone = 1'b1;
  logic       extTrig = 1'b0;
  logic       compIn;
  logic [1:0] rdSel;
  logic [9:0] rdData;
  logic [9:0] dacCode;
  logic       sampleEn;
  logic [1:0] convCh;
  logic       startBit;
  logic       scanMode;
  logic [1:0] chSel;
  logic       doneFlag;
  logic       irq;
  logic       busy;
  logic       eocPulse;

  logic [9:0] ain [4];
  logic [1:0] mainSel = '0;
  logic [1:0] monSel = '0;
  logic       monBusy = 1'b0;

  int checks = 0;
  int errors = 0;
  int expCh[$];
  int expVal[$];

  always #10 clk = ~clk;  // 50 MHz

  assign compIn = (ain[convCh] >= dacCode);
  assign rdSel  = monBusy ? monSel : mainSel;

  sar_seq_top dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wrStart(wrStart), .wrScan(wrScan),
    .wrCh(wrCh), .wrIntEn(wrIntEn), .wrDone(wrDone), .extTrig(extTrig),
    .compIn(compIn), .rdSel(rdSel), .rdData(rdData), .dacCode(dacCode),
    .sampleEn(sampleEn), .convCh(convCh), .startBit(startBit), .scanMode(scanMode),
    .chSel(chSel), .doneFlag(doneFlag), .irq(irq), .busy(busy), .eocPulse(eocPulse)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(logic st, logic sc, logic [1:0] ch, logic ie, logic dn);
    @(negedge clk);
    ctrlWr = 1'b1; wrStart = st; wrScan = sc; wrCh = ch; wrIntEn = ie; wrDone = dn;
    @(posedge clk);
    @(negedge clk);
    ctrlWr = 1'b0; wrDone = 1'b1;
  endtask

  task automatic push(int ch);
    expCh.push_back(ch);
    expVal.push_back(int'(ain[ch]));
  endtask

  task automatic waitStartLow(output int n);
    n = 0;
    while (startBit && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runSingle(logic [1:0] ch, logic [9:0] v);
    int n;
    ain[ch] = v;
    push(ch);
    wr(1'b1, 1'b0, ch, 1'b0, 1'b0);
    waitStartLow(n);
    chk("R3 latency", n, 12);
    chk("R3 done", doneFlag, 1);
    chk("R3 busy", busy, 0);
    chk("R10 irq off", irq, 0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (eocPulse) begin
        if (expCh.size() == 0) begin
          chk("R6 unexpected result", 1, 0);
        end else begin
          int c, v;
          c = expCh.pop_front();
          v = expVal.pop_front();
          monSel = 2'(c);
          monBusy = 1'b1;
          #1;
          chk("R2/R4 result", int'(rdData), v);
          monBusy = 1'b0;
        end
      end
    end
  end

  initial begin
    #(20ns * 150000);
    chk("watchdog", 1, 0);
    finishRun();
  end

  initial begin
    int cnt;
    int n;
    for (int i = 0; i < 4; i++) ain[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start", startBit, 0);
    chk("R1 done", doneFlag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 eoc", eocPulse, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      mainSel = 2'(i);
      #1;
      chk("R1 data reg", int'(rdData), 0);
    end
    chk("R1 mode", scanMode, 0);
    chk("R1 chsel", chSel, 0);

    // R2 / R3 single conversions, mode+channel loaded with start
    runSingle(2'd2, 10'h2A5);
    runSingle(2'd0, 10'h000);
    runSingle(2'd3, 10'h3FF);
    runSingle(2'd1, 10'h200);
    runSingle(2'd1, 10'h1FF);
    mainSel = 2'd2; #1;
    chk("R2 other reg kept", int'(rdData), 10'h2A5);
    mainSel = 2'd3; #1;
    chk("R2 other reg kept", int'(rdData), 10'h3FF);

    // R9 done sticky: write 1 keeps, write 0 clears
    wr(1'b0, 1'b0, 2'd1, 1'b0, 1'b1);
    chk("R9 write1 keeps", doneFlag, 1);
    wr(1'b0, 1'b0, 2'd1, 1'b0, 1'b0);
    chk("R9 write0 clears", doneFlag, 0);

    // R4 / R5 scan over group 0..3
    ain[0] = 10'h011; ain[1] = 10'h155; ain[2] = 10'h2AA; ain[3] = 10'h3F0;
    for (int i = 0; i < 4; i++) push(i);
    wr(1'b1, 1'b1, 2'd3, 1'b0, 1'b1);
    cnt = 0;
    n = 0;
    while (!doneFlag && n < 200) begin
      @(negedge clk);
      n++;
      if (eocPulse) cnt++;
    end
    chk("R5 done after whole group", cnt, 4);
    chk("R5 start stays", startBit, 1);

    // R8 mode/channel write ignored while running; also clears done
    for (int i = 0; i < 4; i++) push(i);
    wr(1'b1, 1'b0, 2'd1, 1'b0, 1'b0);
    chk("R8 mode kept", scanMode, 1);
    chk("R8 chsel kept", chSel, 3);
    chk("R9 cleared mid scan", doneFlag, 0);
    cnt = 0;
    n = 0;
    while (!doneFlag && n < 200) begin
      @(negedge clk);
      n++;
      if (eocPulse) cnt++;
    end
    chk("R5 repeat pass", cnt, 4);

    // R6 stop the scan mid conversion and clear done
    wr(1'b0, 1'b1, 2'd3, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 idle", busy, 0);
    repeat (30) @(negedge clk);
    chk("R6 no done", doneFlag, 0);
    chk("R6 still idle", busy, 0);
    chk("R6 no pending results", expCh.size(), 0);

    // R7 external trigger, R10 interrupt
    wr(1'b0, 1'b0, 2'd1, 1'b1, 1'b0);
    chk("R8 sel loads when stopped", chSel, 1);
    ain[1] = 10'h0C3;
    push(1);
    @(negedge clk);
    extTrig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    extTrig = 1'b0;
    chk("R7 trigger sets start", startBit, 1);
    waitStartLow(n);
    chk("R7 done", doneFlag, 1);
    chk("R10 irq on", irq, 1);
    wr(1'b0, 1'b0, 2'd1, 1'b0, 1'b1);
    chk("R10 irq off by enable", irq, 0);
    chk("R10 done kept", doneFlag, 1);
    wr(1'b0, 1'b0, 2'd1, 1'b1, 1'b0);
    chk("R10 irq off by done", irq, 0);

    // R7 trigger wins over a clearing write on the same edge
    @(negedge clk);
    extTrig = 1'b1; ctrlWr = 1'b1; wrStart = 1'b0; wrScan = 1'b0; wrCh = 2'd1; wrIntEn = 1'b0;
    push(1);
    @(posedge clk);
    @(negedge clk);
    extTrig = 1'b0; ctrlWr = 1'b0;
    chk("R7 trigger beats write", startBit, 1);
    waitStartLow(n);
    wr(1'b0, 1'b0, 2'd2, 1'b0, 1'b0);

    // R9 collision: clearing write on the same edge as the hardware set
    ain[2] = 10'h155;
    push(2);
    wr(1'b1, 1'b0, 2'd2, 1'b0, 1'b0);
    repeat (11) @(posedge clk);
    @(negedge clk);
    ctrlWr = 1'b1; wrStart = 1'b0; wrScan = 1'b0; wrCh = 2'd2; wrIntEn = 1'b0; wrDone = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ctrlWr = 1'b0; wrDone = 1'b1;
    chk("R9 set beats clear", doneFlag, 1);
    chk("R3 start cleared", startBit, 0);
    repeat (3) @(negedge clk);
    chk("R2 all results seen", expCh.size(), 0);
    finishRun();
  end

endmodule